// File: doc/BRIEF.md
# SMRAM Lock and Protected-Segment Guard

This block sits in a memory controller between the CPU's byte-wide memory port and the DRAM. It holds two byte-wide configuration registers. The control register carries an open bit, a close bit, a lock bit and a global enable bit. The extended register carries a segment enable and a two-bit size code. Configuration writes take effect at the clock edge, and configuration reads are combinational.

The protected segment occupies the top of installed RAM. Its size is 1, 2 or 8 MB, or a separately supplied extended size when the size code is all ones. Its base is the installed size minus the segment size. When both the segment enable and the global enable are set, an access from outside management mode that falls inside the segment is stopped, unless the open bit is set. A stopped read returns 0xFF and a stopped write never reaches DRAM. Every other access is forwarded to DRAM unchanged, in the same cycle.

Software sets the lock bit once the segment is configured. From then until a reset, the open bit is held at zero and the protection settings cannot be changed.

Top module: `smram_guard`

## Requirements
- R1: After a synchronous reset both configuration registers read 0x00 and the lock bit is clear.
- R2: While unlocked, writing the control register (select 0) with bit 6 set makes the open bit read 1; writing it with bit 6 clear makes the open bit read 0.
- R3: A control write with bit 4 (lock) set leaves lock reading 1 and open reading 0, even if bit 6 was set in the same write.
- R4: While locked, no control write can set the open bit or clear the lock bit.
- R5: While locked, writes to the extended register (select 1) and changes to the global enable (control bit 3) are ignored, and the registers keep their values.
- R6: Only reset clears the lock. After a reset the open bit can be set and cleared again.
- R7: Extended register bit 0 is the segment enable and bits 2:1 are the size code. The codes map as follows: 00 gives 1 MB, 01 gives 2 MB, 10 gives 8 MB and 11 gives the `ext_mb` input. The segment covers the 1 MB units from `ram_mb - size` up to `ram_mb - 1`.
- R8: A read is stopped when all of the following hold: segment enable is 1, global enable is 1, the access is outside management mode, open is 0, and the address lies inside the segment. A stopped read returns 0xFF and raises no DRAM request.
- R9: A write stopped under the conditions of R8 raises no DRAM request, so memory is left untouched.
- R10: An access to the byte just below the segment base, or to any address at or above `ram_mb` MB, is forwarded to DRAM, and DRAM read data is returned.
- R11: Accesses made in management mode, accesses made while open is set, and accesses made while either enable is clear are all forwarded to DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 extended |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for the selected register |
| ram_mb | input | ADDR_W-20 | Installed RAM size in MB (static) |
| ext_mb | input | ADDR_W-20 | Extended segment size in MB (static) |
| cpu_req | input | 1 | CPU access valid |
| cpu_we | input | 1 | CPU access is a write |
| cpu_smm | input | 1 | CPU access is made in management mode |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| dram_req | output | 1 | Access forwarded to DRAM |
| dram_we | output | 1 | Forwarded access is a write |
| dram_addr | output | ADDR_W | DRAM byte address |
| dram_wdata | output | 8 | DRAM write data |
| dram_rdata | input | 8 | DRAM read data |

## Verification
The routing is first driven with directed probes at four addresses for every size code: one byte below the base, the base itself, the last byte of RAM and the first byte above RAM. These probes separate a wrong size decode from an off-by-one in the range compare. The same probes are repeated in management mode, with open set and with each enable cleared, which shows which term of the stop condition is missing. The lock is tested with writes that set open and lock together, then with attempts to reopen, unlock or retune the registers, and finally across a reset. A seeded random mix of register writes, occasional resets and boundary-biased accesses is then checked against a requirement-level model of both registers, which catches interactions the directed sequence does not reach.

// File: rtl/smram_guard_pkg.sv
package smram_guard_pkg;

    localparam int MB_SHIFT  = 20;
    localparam int DATA_W    = 8;
    localparam logic [DATA_W-1:0] BLOCKED_FILL = 8'hFF;

    // control register bit positions
    localparam int OPEN_BIT  = 6;
    localparam int CLOSE_BIT = 5;
    localparam int LOCK_BIT  = 4;
    localparam int GEN_BIT   = 3;
    // extended register bit positions
    localparam int SEGEN_BIT = 0;
    localparam int CODE_LO   = 1;
    localparam int CODE_HI   = 2;

    typedef enum logic [1:0] {
        SZ_1MB = 2'b00,
        SZ_2MB = 2'b01,
        SZ_8MB = 2'b10,
        SZ_EXT = 2'b11
    } seg_code_e;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_EXT  = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic open;
        logic close;
        logic lock;
        logic gen;
    } ctrl_reg_t;

    typedef struct packed {
        seg_code_e code;
        logic      seg_en;
    } ext_reg_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_reg_t c);
        logic [DATA_W-1:0] b;
        b = '0;
        b[OPEN_BIT]  = c.open;
        b[CLOSE_BIT] = c.close;
        b[LOCK_BIT]  = c.lock;
        b[GEN_BIT]   = c.gen;
        return b;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ext(input ext_reg_t e);
        logic [DATA_W-1:0] b;
        b = '0;
        b[SEGEN_BIT]       = e.seg_en;
        b[CODE_HI:CODE_LO] = e.code;
        return b;
    endfunction

endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
    import smram_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output ctrl_reg_t         ctrl_o,
    output ext_reg_t          ext_o
);

    ctrl_reg_t ctrl_q;
    ext_reg_t  ext_q;
    logic      wr_ctrl;
    logic      wr_ext;

    assign wr_ctrl = cfg_wr && (cfg_sel == SEL_CTRL);
    assign wr_ext  = cfg_wr && (cfg_sel == SEL_EXT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ext_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.close <= cfg_wdata[CLOSE_BIT];
                if (!ctrl_q.lock) begin
                    ctrl_q.lock <= cfg_wdata[LOCK_BIT];
                    ctrl_q.open <= cfg_wdata[OPEN_BIT] & ~cfg_wdata[LOCK_BIT];
                    ctrl_q.gen  <= cfg_wdata[GEN_BIT];
                end
            end
            if (wr_ext && !ctrl_q.lock) begin
                ext_q.seg_en <= cfg_wdata[SEGEN_BIT];
                ext_q.code   <= seg_code_e'(cfg_wdata[CODE_HI:CODE_LO]);
            end
        end
    end

    assign cfg_rdata = (cfg_sel == SEL_CTRL) ? pack_ctrl(ctrl_q) : pack_ext(ext_q);
    assign ctrl_o    = ctrl_q;
    assign ext_o     = ext_q;

    // R3
    lock_clears_open_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && cfg_wdata[LOCK_BIT]) |=> (ctrl_q.lock && !ctrl_q.open));

    // R4
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.lock |=> (ctrl_q.lock && !ctrl_q.open));

    // R5
    locked_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.lock |=> ($stable(ext_q) && $stable(ctrl_q.gen)));

endmodule

// File: rtl/smram_seg_window.sv
module smram_seg_window
    import smram_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-MB_SHIFT-1:0] ram_mb,
    input  logic [ADDR_W-MB_SHIFT-1:0] ext_mb,
    input  seg_code_e                  code,
    input  logic [ADDR_W-1:0]          addr,
    output logic                       hit
);

    localparam int MB_W = ADDR_W - MB_SHIFT;

    logic [MB_W-1:0] seg_mb;
    logic [MB_W-1:0] base_mb;
    logic [MB_W-1:0] addr_mb;

    always_comb begin
        unique case (code)
            SZ_1MB:  seg_mb = MB_W'(1);
            SZ_2MB:  seg_mb = MB_W'(2);
            SZ_8MB:  seg_mb = MB_W'(8);
            default: seg_mb = ext_mb;
        endcase
    end

    // a segment larger than RAM is clamped to start at zero
    assign base_mb = (seg_mb > ram_mb) ? '0 : (ram_mb - seg_mb);
    assign addr_mb = addr[ADDR_W-1:MB_SHIFT];
    assign hit     = (addr_mb >= base_mb) && (addr_mb < ram_mb);

endmodule

// File: rtl/smram_access_gate.sv
module smram_access_gate
    import smram_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_reg_t         ctrl,
    input  ext_reg_t          ext,
    input  logic              in_seg,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_smm,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              dram_req,
    output logic              dram_we,
    output logic [ADDR_W-1:0] dram_addr,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);

    logic guard_armed;
    logic blocked;

    assign guard_armed = ext.seg_en && ctrl.gen && !ctrl.open;
    assign blocked     = cpu_req && in_seg && guard_armed && !cpu_smm;

    assign dram_req   = cpu_req && !blocked;
    assign dram_we    = cpu_we && dram_req;
    assign dram_addr  = cpu_addr;
    assign dram_wdata = cpu_wdata;
    assign cpu_rdata  = blocked ? BLOCKED_FILL : dram_rdata;

    // R8
    stopped_read_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we && !dram_req) |-> (cpu_rdata == BLOCKED_FILL));

    // R10
    outside_passes_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !in_seg) |-> dram_req);

    // R11
    smm_passes_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_smm) |-> (dram_req && (dram_we == cpu_we)));

    // R9
    no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        dram_we |-> (cpu_req && cpu_we));

endmodule

// File: rtl/smram_guard.sv
module smram_guard
    import smram_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_wr,
    input  logic                       cfg_sel,
    input  logic [DATA_W-1:0]          cfg_wdata,
    output logic [DATA_W-1:0]          cfg_rdata,
    input  logic [ADDR_W-MB_SHIFT-1:0] ram_mb,
    input  logic [ADDR_W-MB_SHIFT-1:0] ext_mb,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic                       cpu_smm,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [DATA_W-1:0]          cpu_wdata,
    output logic [DATA_W-1:0]          cpu_rdata,
    output logic                       dram_req,
    output logic                       dram_we,
    output logic [ADDR_W-1:0]          dram_addr,
    output logic [DATA_W-1:0]          dram_wdata,
    input  logic [DATA_W-1:0]          dram_rdata
);

    ctrl_reg_t ctrl;
    ext_reg_t  ext;
    logic      in_seg;

    smram_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctrl_o    (ctrl),
        .ext_o     (ext)
    );

    smram_seg_window #(.ADDR_W(ADDR_W)) u_window (
        .ram_mb (ram_mb),
        .ext_mb (ext_mb),
        .code   (ext.code),
        .addr   (cpu_addr),
        .hit    (in_seg)
    );

    smram_access_gate #(.ADDR_W(ADDR_W)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .ext        (ext),
        .in_seg     (in_seg),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_smm    (cpu_smm),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .dram_req   (dram_req),
        .dram_we    (dram_we),
        .dram_addr  (dram_addr),
        .dram_wdata (dram_wdata),
        .dram_rdata (dram_rdata)
    );

    // R6
    reset_unlocks_chk: assert property (@(posedge clk)
        rst |=> (cfg_sel != SEL_CTRL || cfg_rdata == 8'h00));

endmodule

// File: tb/smram_guard_tb.sv
module smram_guard_tb;

    localparam int ADDR_W = 32;
    localparam int MB_W   = ADDR_W - 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        cfg_rdata;
    logic [MB_W-1:0]   ram_mb = MB_W'(128);
    logic [MB_W-1:0]   ext_mb = MB_W'(16);
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic              cpu_smm = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic [7:0]        cpu_rdata;
    logic              dram_req;
    logic              dram_we;
    logic [ADDR_W-1:0] dram_addr;
    logic [7:0]        dram_wdata;
    logic [7:0]        dram_rdata;

    assign dram_rdata = dram_addr[7:0] ^ 8'h3C;

    always #10 clk = ~clk;

    smram_guard #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ram_mb(ram_mb),
        .ext_mb(ext_mb), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_smm(cpu_smm), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .dram_req(dram_req), .dram_we(dram_we),
        .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model of the registers, from the requirements
    bit       m_open, m_close, m_lock, m_gen, m_en;
    bit [1:0] m_code;

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int seg_size();
        case (m_code)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 8;
            default: return int'(ext_mb);
        endcase
    endfunction

    function automatic int base_mb();
        int s;
        s = seg_size();
        return (s > int'(ram_mb)) ? 0 : int'(ram_mb) - s;
    endfunction

    function automatic bit exp_stop(input logic [31:0] a, input bit smm);
        int amb;
        amb = int'(a >> 20);
        return m_en && m_gen && !m_open && !smm && amb >= base_mb() && amb < int'(ram_mb);
    endfunction

    function automatic int ctrl_byte();
        return (int'(m_open) << 6) | (int'(m_close) << 5) | (int'(m_lock) << 4) | (int'(m_gen) << 3);
    endfunction

    function automatic int ext_byte();
        return (int'(m_code) << 1) | int'(m_en);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_open = 0; m_close = 0; m_lock = 0; m_gen = 0; m_en = 0; m_code = 0;
    endtask

    task automatic cfg_write(input bit sel, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (sel == 1'b0) begin
            m_close = d[5];
            if (!m_lock) begin
                m_lock = d[4];
                m_open = d[6] & ~d[4];
                m_gen  = d[3];
            end
        end else if (!m_lock) begin
            m_en = d[0]; m_code = d[2:1];
        end
    endtask

    task automatic cfg_check(input bit sel, input string req);
        cfg_sel = sel;
        #1;
        check(req, int'(cfg_rdata), sel ? ext_byte() : ctrl_byte());
    endtask

    task automatic access(input logic [31:0] a, input bit we, input bit smm, input string req);
        bit stop;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_smm = smm; cpu_addr = a;
        cpu_wdata = a[15:8];
        #1;
        stop = exp_stop(a, smm);
        check({req, " dram_req"}, int'(dram_req), int'(!stop));
        if (we) check({req, " dram_we"}, int'(dram_we), int'(!stop));
        else    check({req, " rdata"}, int'(cpu_rdata), stop ? 32'hFF : int'(a[7:0] ^ 8'h3C));
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_smm = 1'b0;
    endtask

    task automatic probe_edges(input bit smm, input string req);
        logic [31:0] b, t;
        b = 32'(base_mb()) << 20;
        t = 32'(ram_mb) << 20;
        access(b - 1, 1'b0, smm, {req, " below base"});
        access(b,     1'b0, smm, {req, " base read"});
        access(b + 4, 1'b1, smm, {req, " base write"});
        access(t - 1, 1'b0, smm, {req, " top byte"});
        access(t,     1'b0, smm, {req, " above ram"});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got 0x0 expected 0x1 (run completed)");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        cfg_check(1'b0, "R1 ctrl reset");
        cfg_check(1'b1, "R1 ext reset");

        cfg_write(1'b0, 8'h40); cfg_check(1'b0, "R2 open set");
        cfg_write(1'b0, 8'h00); cfg_check(1'b0, "R2 open clear");

        // arm protection and sweep every size code
        cfg_write(1'b0, 8'h28);
        for (int c = 0; c < 4; c++) begin
            cfg_write(1'b1, 8'((c << 1) | 1));
            cfg_check(1'b1, "R7 ext code");
            probe_edges(1'b0, "R7 R8 R9 R10 window");
            probe_edges(1'b1, "R11 smm");
        end
        cfg_write(1'b0, 8'h48); probe_edges(1'b0, "R11 open");
        cfg_write(1'b0, 8'h00); probe_edges(1'b0, "R11 gen off");
        cfg_write(1'b0, 8'h08); cfg_write(1'b1, 8'h04);
        probe_edges(1'b0, "R11 seg off");

        // lock with open requested in the same write
        cfg_write(1'b1, 8'h05);
        cfg_write(1'b0, 8'h58); cfg_check(1'b0, "R3 lock clears open");
        probe_edges(1'b0, "R8 locked window");
        cfg_write(1'b0, 8'h48); cfg_check(1'b0, "R4 reopen refused");
        cfg_write(1'b0, 8'h40); cfg_check(1'b0, "R4 unlock refused");
        cfg_write(1'b0, 8'h00); cfg_check(1'b0, "R5 gen frozen");
        cfg_write(1'b1, 8'h00); cfg_check(1'b1, "R5 ext frozen");
        probe_edges(1'b0, "R5 still guarded");

        do_reset();
        cfg_check(1'b0, "R6 unlocked after reset");
        cfg_write(1'b0, 8'h40); cfg_check(1'b0, "R6 open set");
        cfg_write(1'b0, 8'h00); cfg_check(1'b0, "R6 open clear");

        ext_mb = MB_W'(200);
        cfg_write(1'b0, 8'h08); cfg_write(1'b1, 8'h07);
        probe_edges(1'b0, "R7 oversize segment");
        ext_mb = MB_W'(16);

        for (int i = 0; i < 1500; i++) begin
            int r;
            r = int'($urandom % 32);
            if (r == 0 && ($urandom % 8) == 0) begin
                do_reset();
                cfg_check(1'b0, "R1 R6 random reset");
            end else if (r < 4) begin
                logic [7:0] d;
                d = 8'($urandom);
                if (($urandom % 6) != 0) d[4] = 1'b0;
                cfg_write(1'b0, d);
                cfg_check(1'b0, "R2 R3 R4 R5 random ctrl");
            end else if (r < 7) begin
                cfg_write(1'b1, 8'($urandom));
                cfg_check(1'b1, "R5 R7 random ext");
            end else begin
                logic [31:0] a;
                int pick;
                pick = int'($urandom % 5);
                case (pick)
                    0: a = (32'(base_mb()) << 20) - 32'($urandom % 4) - 1;
                    1: a = (32'(base_mb()) << 20) + 32'($urandom % 4);
                    2: a = (32'(ram_mb) << 20) - 32'($urandom % 4) - 1;
                    3: a = (32'(ram_mb) << 20) + 32'($urandom % 4);
                    default: a = 32'($urandom % (32'(ram_mb) << 20));
                endcase
                access(a, 1'($urandom), (($urandom % 4) == 0), "R8 R9 R10 R11 random access");
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule